// File: doc/BRIEF.md
# Transfer Descriptor Queue

This block sits between software and a block-oriented SD data engine. Software queues transfer descriptors for either direction. Each descriptor pairs a memory buffer address with a card block address and moves one 512-byte block. The block holds one queue per direction and hands the engine a single descriptor at a time, tagged with its direction, over a valid/ready handshake. It then waits for the engine's completion report before it issues anything else.

A descriptor is entered by two back-to-back 32-bit writes to the port for its direction. The buffer address goes first and the block address second. Software reads the free slots left in each queue from one packed status word. Completion outcomes from the engine collect in a sticky data status register, which software clears by writing zero. The serializer, DMA master, CRC logic and memory lie outside this block.

Top module: `sdDescQueue`

## Requirements
- R1: After reset both queues report DEPTH (8) free slots, the data status register reads 0, and descValid is low.
- R2: Writing to offset 0x60 queues a receive descriptor and writing to offset 0x80 queues a transmit descriptor. The first write carries the buffer address and the second carries the block address. After the first word alone, the free count is unchanged and nothing is offered downstream.
- R3: A read at offset 0x50 returns the free transmit slots in bits [7:0] and the free receive slots in bits [15:8]. All other bits read 0.
- R4: A descriptor started while its queue has no free slot is dropped. The free count stays 0 and the dropped descriptor is never issued.
- R5: Within one direction, descriptors are issued in the order they were written.
- R6: Once a descriptor has been accepted (descValid and descReady high together), no further descriptor is offered until the engine pulses doneValid.
- R7: When both directions have descriptors pending, issue alternates: the direction not served last goes first.
- R8: While descValid is high and descReady is low, descValid stays high and the offered direction and addresses do not change.
- R9: A direction regains one free slot when the engine reports completion of its descriptor, whatever the outcome.
- R10: A read at offset 0x54 returns the data status. Bit 0 means transfer successful, bit 1 retry error, bit 2 FIFO error, bit 4 command error and bit 5 transmission error. doneStatus uses the same bit layout and is ORed in at each completion. Bit 3 is always 0. Set bits stay set.
- R11: A write to offset 0x54 keeps only the status bits that are also 1 in the written value, so writing zero clears all of them.
- R12: descIsTx is 1 for a descriptor written through the transmit port and 0 for one written through the receive port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 8 | Register write byte offset |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 8 | Register read byte offset |
| regRdData | output | 32 | Register read data (combinational) |
| descValid | output | 1 | A descriptor is offered to the engine |
| descReady | input | 1 | Engine accepts the offered descriptor |
| descIsTx | output | 1 | Direction of offered descriptor (1 = transmit) |
| descBufAddr | output | 32 | Memory buffer address of the offered descriptor |
| descBlkAddr | output | 32 | Card block address of the offered descriptor |
| doneValid | input | 1 | Engine reports completion of the outstanding descriptor |
| doneStatus | input | 6 | Completion outcome bits, same layout as the data status |

## Verification
On every cycle, the assertions check the handshake hold, the single outstanding transfer after an accept, the upper bound on free counts, the rule that no push lands on a full queue, and the stickiness and clearing of the status bits. Only the directed scenarios can show that descriptors carry the right addresses in the right order. The same applies to alternation between directions, to a half-written descriptor staying hidden, to a dropped descriptor never surfacing, and to a free slot coming back after a failed transfer.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam logic [7:0] OFS_FREE = 8'h50;
  localparam logic [7:0] OFS_STS  = 8'h54;
  localparam logic [7:0] OFS_RX   = 8'h60;
  localparam logic [7:0] OFS_TX   = 8'h80;
  // valid status bits: 0,1,2,4,5 (bit 3 reserved)
  localparam logic [5:0] STS_MASK = 6'b110111;

  // index 0 = receive, index 1 = transmit
  typedef struct packed {
    logic [1:0] stage;   // latch first descriptor word
    logic [1:0] push;    // second word completes a descriptor
    logic [1:0] pop;     // engine accepted head of queue
    logic       sel;     // direction currently offered
    logic       stsWr;   // software write to data status
    logic       stsSet;  // completion merges status bits
  } dqStrobe_t;
endpackage

// File: rtl/dqCtrl.sv
module dqCtrl
  import sdq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [1:0][CNT_W-1:0]      occ,
  input  logic                       descReady,
  input  logic                       doneValid,
  output dqStrobe_t                  strb,
  output logic [1:0][CNT_W-1:0]      freeCnt,
  output logic                       descValid,
  output logic                       descIsTx
);
  typedef enum logic [1:0] {IDLE, OFFER, BUSY} issueState_t;

  issueState_t state;
  logic        selTx;
  logic        lastTx;
  logic [1:0]  half;
  logic [1:0]  portHit;
  logic [1:0]  pend;
  logic [1:0]  inflight;
  logic        pickTx;

  always_comb begin
    portHit[0] = wrEn && (wrAddr == ADDR_W'(OFS_RX));
    portHit[1] = wrEn && (wrAddr == ADDR_W'(OFS_TX));
    for (int d = 0; d < 2; d++) begin
      pend[d]     = (occ[d] != '0);
      inflight[d] = (state == BUSY) && (selTx == (d == 1));
      freeCnt[d]  = CNT_W'(DEPTH) - occ[d] - CNT_W'(inflight[d]);
    end
    pickTx = pend[1] && (!pend[0] || !lastTx);
  end

  always_comb begin
    strb = '0;
    for (int d = 0; d < 2; d++) begin
      strb.stage[d] = portHit[d] && !half[d] && (freeCnt[d] != '0);
      strb.push[d]  = portHit[d] && half[d];
      strb.pop[d]   = (state == OFFER) && descReady && (selTx == (d == 1));
    end
    strb.sel    = selTx;
    strb.stsWr  = wrEn && (wrAddr == ADDR_W'(OFS_STS));
    strb.stsSet = (state == BUSY) && doneValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= IDLE;
      selTx  <= 1'b0;
      lastTx <= 1'b0;
      half   <= '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (strb.stage[d])     half[d] <= 1'b1;
        else if (strb.push[d]) half[d] <= 1'b0;
      end
      unique case (state)
        IDLE: if (pend != '0) begin
          selTx <= pickTx;
          state <= OFFER;
        end
        OFFER: if (descReady) begin
          lastTx <= selTx;
          state  <= BUSY;
        end
        BUSY: if (doneValid) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign descValid = (state == OFFER);
  assign descIsTx  = selTx;

  // R8: offer held until accepted
  a_r8_offer_hold: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descIsTx));
  // R6: nothing offered right after an accept
  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady |=> !descValid);
  // R9: free counts never exceed the queue depth
  a_r9_free_bound: assert property (@(posedge clk) disable iff (!rstN)
    freeCnt[0] <= CNT_W'(DEPTH) && freeCnt[1] <= CNT_W'(DEPTH));
endmodule

// File: rtl/dqData.sv
module dqData
  import sdq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dqStrobe_t             strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [5:0]            doneStatus,
  input  logic [1:0][CNT_W-1:0] freeCnt,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic [1:0][CNT_W-1:0] occ,
  output logic [DATA_W-1:0]     descBufAddr,
  output logic [DATA_W-1:0]     descBlkAddr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0][DATA_W-1:0] headBuf;
  logic [1:0][DATA_W-1:0] headBlk;
  logic [5:0]             sts;
  logic [5:0]             stsNext;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [DATA_W-1:0] bufMem [DEPTH];
    logic [DATA_W-1:0] blkMem [DEPTH];
    logic [DATA_W-1:0] firstWord;
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr  <= '0;
        rdPtr  <= '0;
        occ[d] <= '0;
      end else begin
        if (strb.stage[d]) firstWord <= wrData;
        if (strb.push[d]) begin
          bufMem[wrPtr] <= firstWord;
          blkMem[wrPtr] <= wrData;
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (strb.pop[d])
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        occ[d] <= occ[d] + CNT_W'(strb.push[d]) - CNT_W'(strb.pop[d]);
      end
    end

    assign headBuf[d] = bufMem[rdPtr];
    assign headBlk[d] = blkMem[rdPtr];

    // R4: a descriptor is never pushed into a full queue
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      strb.push[d] |-> occ[d] < CNT_W'(DEPTH));
  end

  assign descBufAddr = headBuf[strb.sel];
  assign descBlkAddr = headBlk[strb.sel];

  always_comb begin
    stsNext = sts;
    if (strb.stsWr)  stsNext = stsNext & wrData[5:0];
    if (strb.stsSet) stsNext = stsNext | (doneStatus & STS_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) sts <= '0;
    else       sts <= stsNext;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(OFS_FREE))
      rdData[15:0] = {8'(freeCnt[0]), 8'(freeCnt[1])};
    else if (rdAddr == ADDR_W'(OFS_STS))
      rdData[5:0] = sts;
  end

  // R10: status bits are sticky without a software write
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stsWr |=> (sts & $past(sts)) == $past(sts));
  // R11: writing zero with no completion clears all bits
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.stsWr && wrData[5:0] == 6'd0 && !strb.stsSet |=> sts == 6'd0);
endmodule

// File: rtl/sdDescQueue.sv
module sdDescQueue
  import sdq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              descValid,
  input  logic              descReady,
  output logic              descIsTx,
  output logic [DATA_W-1:0] descBufAddr,
  output logic [DATA_W-1:0] descBlkAddr,
  input  logic              doneValid,
  input  logic [5:0]        doneStatus
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dqStrobe_t             strb;
  logic [1:0][CNT_W-1:0] occ;
  logic [1:0][CNT_W-1:0] freeCnt;

  dqCtrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regWrAddr),
    .occ(occ), .descReady(descReady), .doneValid(doneValid),
    .strb(strb), .freeCnt(freeCnt), .descValid(descValid), .descIsTx(descIsTx)
  );

  dqData #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .doneStatus(doneStatus), .freeCnt(freeCnt), .rdAddr(regRdAddr),
    .rdData(regRdData), .occ(occ), .descBufAddr(descBufAddr),
    .descBlkAddr(descBlkAddr)
  );
endmodule

// File: tb/sdDescQueue_tb.sv
module sdDescQueue_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [7:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        descValid;
  logic        descReady = 1'b0;
  logic        descIsTx;
  logic [31:0] descBufAddr;
  logic [31:0] descBlkAddr;
  logic        doneValid = 1'b0;
  logic [5:0]  doneStatus = '0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdDescQueue u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .descValid(descValid), .descReady(descReady), .descIsTx(descIsTx),
    .descBufAddr(descBufAddr), .descBlkAddr(descBlkAddr),
    .doneValid(doneValid), .doneStatus(doneStatus)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] addr, output logic [31:0] data);
    regRdAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic checkReg(input logic [7:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] v;
    regRead(addr, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic wrDesc(input bit isTx, input logic [31:0] bufA, input logic [31:0] blkA);
    regWrite(isTx ? 8'h80 : 8'h60, bufA);
    regWrite(isTx ? 8'h80 : 8'h60, blkA);
  endtask

  task automatic take(input bit expTx, input logic [31:0] bufA, input logic [31:0] blkA,
                      input string req);
    int n = 0;
    while (!descValid && n < 50) begin @(negedge clk); n++; end
    check(descValid === 1'b1, {req, " valid"}, 32'(descValid), 32'd1);
    check(descIsTx === expTx, {req, " R12 dir"}, 32'(descIsTx), 32'(expTx));
    check(descBufAddr === bufA, {req, " buf"}, descBufAddr, bufA);
    check(descBlkAddr === blkA, {req, " blk"}, descBlkAddr, blkA);
    // R8: hold one extra cycle without ready, offer must persist
    @(negedge clk);
    check(descValid === 1'b1 && descBufAddr === bufA, "R8 hold", 32'(descValid), 32'd1);
    descReady = 1'b1;
    @(negedge clk);
    descReady = 1'b0;
  endtask

  task automatic complete(input logic [5:0] st);
    doneValid = 1'b1; doneStatus = st;
    @(negedge clk);
    doneValid = 1'b0; doneStatus = '0;
  endtask

  task automatic t_reset();
    checkReg(8'h50, 32'h0808, "R1 R3 reset free");
    checkReg(8'h54, 32'h0, "R1 reset status");
    check(descValid === 1'b0, "R1 no valid", 32'(descValid), 32'd0);
  endtask

  task automatic t_single_tx();
    regWrite(8'h80, 32'h0000_1000);
    checkReg(8'h50, 32'h0808, "R2 half desc free");
    repeat (3) @(negedge clk);
    check(descValid === 1'b0, "R2 half desc hidden", 32'(descValid), 32'd0);
    regWrite(8'h80, 32'h0000_0022);
    checkReg(8'h50, 32'h0807, "R2 R3 tx free after");
    take(1'b1, 32'h1000, 32'h22, "R2");
    complete(6'b000001);
    checkReg(8'h50, 32'h0808, "R9 tx slot back");
    checkReg(8'h54, 32'h1, "R10 success bit");
  endtask

  task automatic t_clear();
    regWrite(8'h54, 32'h0);
    checkReg(8'h54, 32'h0, "R11 clear");
  endtask

  task automatic t_errors();
    wrDesc(1'b0, 32'hA000, 32'h5);
    checkReg(8'h50, 32'h0708, "R3 rx free in high byte");
    take(1'b0, 32'hA000, 32'h5, "R12 rx");
    complete(6'b000010);
    checkReg(8'h50, 32'h0808, "R9 slot back after failure");
    wrDesc(1'b0, 32'hA200, 32'h6);
    take(1'b0, 32'hA200, 32'h6, "R10");
    complete(6'b111100);
    checkReg(8'h54, 32'h36, "R10 ORed bits, bit3 zero");
    regWrite(8'h54, 32'h30);
    checkReg(8'h54, 32'h30, "R11 masked write");
    regWrite(8'h54, 32'h0);
    checkReg(8'h54, 32'h0, "R11 clear to zero");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) wrDesc(1'b0, 32'hB000 + 32'(i), 32'h100 + 32'(i));
    checkReg(8'h50, 32'h0008, "R4 rx full");
    wrDesc(1'b0, 32'hDEAD, 32'hBEEF);
    checkReg(8'h50, 32'h0008, "R4 drop keeps free 0");
    for (int i = 0; i < 8; i++) begin
      take(1'b0, 32'hB000 + 32'(i), 32'h100 + 32'(i), "R5 order");
      complete(6'b000001);
    end
    repeat (5) @(negedge clk);
    check(descValid === 1'b0, "R4 dropped never issued", 32'(descValid), 32'd0);
    checkReg(8'h50, 32'h0808, "R9 all slots back");
  endtask

  task automatic t_alternate();
    wrDesc(1'b1, 32'hC000, 32'h1);
    wrDesc(1'b1, 32'hC001, 32'h2);
    wrDesc(1'b0, 32'hC100, 32'h3);
    wrDesc(1'b0, 32'hC101, 32'h4);
    take(1'b1, 32'hC000, 32'h1, "R7 first"); complete(6'b000001);
    take(1'b0, 32'hC100, 32'h3, "R7 second"); complete(6'b000001);
    take(1'b1, 32'hC001, 32'h2, "R7 third"); complete(6'b000001);
    take(1'b0, 32'hC101, 32'h4, "R7 fourth"); complete(6'b000001);
  endtask

  task automatic t_outstanding();
    wrDesc(1'b1, 32'hE000, 32'h7);
    wrDesc(1'b0, 32'hE100, 32'h8);
    take(1'b1, 32'hE000, 32'h7, "R6");
    for (int i = 0; i < 4; i++) begin
      check(descValid === 1'b0, "R6 no second offer", 32'(descValid), 32'd0);
      @(negedge clk);
    end
    checkReg(8'h50, 32'h0707, "R9 busy slot still held");
    complete(6'b000001);
    take(1'b0, 32'hE100, 32'h8, "R6 after done");
    complete(6'b000001);
    checkReg(8'h50, 32'h0808, "R9 both back");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_tx();
    t_clear();
    t_errors();
    t_fill();
    t_alternate();
    t_outstanding();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule